// File: doc/BRIEF.md
# Pixel Threshold Kernel

This block binarises an 8-bit greyscale image that lives in external memory. Software programs six arguments: a source base address, a destination base address, a column count, a row count, a threshold and a maximum value. It then pulses `start`. The kernel fetches pixels one by one in increasing address order. It compares each pixel against the threshold and stores either the low byte of the maximum value or zero at the matching destination address.

Memory is reached through two independent ports. The read port is a valid/ready request whose data is returned in the same cycle the request is accepted. The write port is a valid/ready request carrying address and data. A fixed four-register datapath sustains one pixel per clock, and reads and writes overlap. The kernel runs one job at a time. `busy` covers the whole job, and a single-cycle `done` pulse marks its end.

Top module: `pxthr_kernel`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `rd_valid` and `wr_valid` are all low.
- R2: `start` is accepted only on a clock edge where `busy` is low. A `start` seen while `busy` is high does not begin another job and does not produce an extra `done`.
- R3: A job reads exactly `n_cols * n_rows` pixels. Read k (counting from 0) uses address `src_base + k`.
- R4: A result is the low 8 bits of `max_val` when the pixel, zero-extended to 32 bits, is strictly greater than the 32-bit `thresh`. Otherwise the result is 0, and this includes a pixel equal to the threshold.
- R5: Write k (counting from 0) uses address `dst_base + k` and carries the result of read k. Writes occur in read order, and there are exactly as many writes as reads.
- R6: With `rd_ready` and `wr_ready` held high, a read handshake occurs on every clock edge from the first read to the last.
- R7: With both ready inputs high, a pixel read on edge t is written on edge t+4. The last write lands (pixels − 1) + 4 edges after the first read.
- R8: Read and write handshakes take place on the same edge. With both ready inputs high, a job of N ≥ 4 pixels has N − 4 edges carrying both.
- R9: While `wr_ready` is low with `wr_valid` high, `wr_data` and `wr_addr` hold. A low `rd_ready` while reads remain stalls the whole datapath and masks `wr_valid`. Under any ready pattern, no result is lost or repeated.
- R10: A job with zero columns or zero rows makes no read or write. When it is accepted on edge S, `done` is high in the cycle after edge S+1.
- R11: `done` is high for exactly one cycle, in the cycle after the edge following the last write handshake. `busy` is high from the accepting edge until the edge at which `done` rises, and low from then on.
- R12: All six arguments are captured on the accepting edge. Changing them during a job changes neither its addresses, its results nor its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Job request, honoured only while idle |
| src_base | input | 32 | Address of the first input pixel |
| dst_base | input | 32 | Address of the first output pixel |
| n_cols | input | 32 | Column count |
| n_rows | input | 32 | Row count |
| thresh | input | 32 | Threshold, compared strictly greater-than |
| max_val | input | 32 | Value whose low byte is written for bright pixels |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| rd_valid | output | 1 | Read request |
| rd_addr | output | 32 | Read address |
| rd_ready | input | 1 | Read accepted, `rd_data` valid this cycle |
| rd_data | input | 8 | Pixel returned for the accepted read |
| wr_valid | output | 1 | Write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 8 | Result byte |
| wr_ready | input | 1 | Write accepted |

## Verification
The assertions assume the memory returns valid `rd_data` in the same cycle that `rd_ready` accepts a read, and that the arguments are stable on the edge where `start` is taken. The bench meets both assumptions. It serves read data combinationally from a byte array indexed by the offset of `rd_addr`. It changes arguments and ready inputs only on falling edges. The ready inputs are either held high or driven from a free-running shift register. Argument changes in the middle of a job are made only after the job has been accepted.

// File: rtl/pxthr_pkg.sv
// Shared widths and control state for the pixel threshold kernel.
// Assumes pixels are one byte and software arguments are one word.
package pxthr_pkg;
    localparam int ARG_W = 32;
    localparam int PIX_W = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pxthr_state_e;
endpackage

// File: rtl/pxthr_ctrl.sv
// Job controller: accepts start while idle, captures every argument on the
// accepting edge and ends the job once the write sequencer has nothing left.
// Assumes wr_more is computed from the captured pixel count.
module pxthr_ctrl
    import pxthr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 2 * ARG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    input  logic [ARG_W-1:0] n_cols,
    input  logic [ARG_W-1:0] n_rows,
    input  logic [ARG_W-1:0] thresh,
    input  logic [ARG_W-1:0] max_val,
    input  logic             wr_more,
    output logic             load,
    output logic             run,
    output logic             busy,
    output logic             done,
    output logic [AW-1:0]    src_q,
    output logic [AW-1:0]    dst_q,
    output logic [CW-1:0]    npix_q,
    output logic [ARG_W-1:0] thr_q,
    output logic [PIX_W-1:0] max_q
);
    pxthr_state_e state;

    // Start is honoured only in the idle state.
    assign load = (state == ST_IDLE) && start;
    assign run  = (state == ST_RUN);
    assign busy = (state != ST_IDLE);

    // State, argument capture and end-of-job pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done   <= 1'b0;
            src_q  <= '0;
            dst_q  <= '0;
            npix_q <= '0;
            thr_q  <= '0;
            max_q  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_RUN;
                        src_q  <= src_base;
                        dst_q  <= dst_base;
                        npix_q <= CW'(n_cols) * CW'(n_rows);
                        thr_q  <= thresh;
                        max_q  <= max_val[PIX_W-1:0];
                    end
                end
                ST_RUN: begin
                    if (!wr_more) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pxthr_addr_seq.sv
// Linear address sequencer: produces base + index and advances on step.
// Assumes CW >= AW and that base and total are stable for the whole job.
module pxthr_addr_seq #(
    parameter int AW = 32,
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] total,
    output logic [AW-1:0] addr,
    output logic          more
);
    logic [CW-1:0] idx;

    // Index counter, cleared at job acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (load) idx <= '0;
        else if (step) idx <= idx + 1'b1;
    end

    // Address and remaining-work flag.
    assign addr = base + idx[AW-1:0];
    assign more = (idx < total);
endmodule

// File: rtl/pxthr_pipe.sv
// Threshold datapath of DEPTH registers advancing together on adv:
// stage 1 holds the pixel, stage 2 the comparison, stage 3 onward the result.
// Assumes DEPTH >= 3 and that thr and maxv stay fixed during a job.
module pxthr_pipe
    import pxthr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             in_v,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [ARG_W-1:0] thr,
    input  logic [PIX_W-1:0] maxv,
    output logic             out_v,
    output logic [PIX_W-1:0] out_pix
);
    localparam int PAD = ARG_W - PIX_W;

    logic [DEPTH:1]            vld;
    logic [PIX_W-1:0]          pix1;
    logic                      hit2;
    logic [DEPTH:3][PIX_W-1:0] res;

    // Shift every stage in lockstep when the datapath may advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= '0;
            pix1 <= '0;
            hit2 <= 1'b0;
            res  <= '0;
        end else if (adv) begin
            vld    <= {vld[DEPTH-1:1], in_v};
            pix1   <= in_pix;
            hit2   <= ({{PAD{1'b0}}, pix1} > thr);
            res[3] <= hit2 ? maxv : '0;
            for (int k = 4; k <= DEPTH; k++) res[k] <= res[k-1];
        end
    end

    assign out_v   = vld[DEPTH];
    assign out_pix = res[DEPTH];
endmodule

// File: rtl/pxthr_kernel.sv
// Top of the pixel threshold kernel: job control, read and write address
// sequencers and a four-stage datapath sharing one advance enable.
// Assumes rd_data is valid in the cycle rd_ready accepts rd_valid.
module pxthr_kernel
    import pxthr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    input  logic [ARG_W-1:0] n_cols,
    input  logic [ARG_W-1:0] n_rows,
    input  logic [ARG_W-1:0] thresh,
    input  logic [ARG_W-1:0] max_val,
    output logic             busy,
    output logic             done,
    output logic             rd_valid,
    output logic [AW-1:0]    rd_addr,
    input  logic             rd_ready,
    input  logic [PIX_W-1:0] rd_data,
    output logic             wr_valid,
    output logic [AW-1:0]    wr_addr,
    output logic [PIX_W-1:0] wr_data,
    input  logic             wr_ready
);
    localparam int CW = 2 * ARG_W;

    logic             load, run;
    logic [AW-1:0]    src_q, dst_q;
    logic [CW-1:0]    npix_q;
    logic [ARG_W-1:0] thr_q;
    logic [PIX_W-1:0] max_q;
    logic             rd_more, wr_more;
    logic             out_v, sink_ok, rd_ok, adv;
    logic             rd_fire, wr_fire;

    pxthr_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_base(src_base), .dst_base(dst_base),
        .n_cols(n_cols), .n_rows(n_rows), .thresh(thresh), .max_val(max_val),
        .wr_more(wr_more), .load(load), .run(run), .busy(busy), .done(done),
        .src_q(src_q), .dst_q(dst_q), .npix_q(npix_q), .thr_q(thr_q), .max_q(max_q)
    );

    pxthr_addr_seq #(.AW(AW), .CW(CW)) u_rd_seq (
        .clk(clk), .rst_n(rst_n), .load(load), .step(rd_fire),
        .base(src_q), .total(npix_q), .addr(rd_addr), .more(rd_more)
    );

    pxthr_addr_seq #(.AW(AW), .CW(CW)) u_wr_seq (
        .clk(clk), .rst_n(rst_n), .load(load), .step(wr_fire),
        .base(dst_q), .total(npix_q), .addr(wr_addr), .more(wr_more)
    );

    pxthr_pipe #(.DEPTH(DEPTH)) u_pipe (
        .clk(clk), .rst_n(rst_n), .adv(adv), .in_v(rd_fire), .in_pix(rd_data),
        .thr(thr_q), .maxv(max_q), .out_v(out_v), .out_pix(wr_data)
    );

    // Joint stall: the output slot must drain and any pending read must answer.
    assign sink_ok  = !out_v || wr_ready;
    assign rd_ok    = rd_ready || !(run && rd_more);
    assign adv      = sink_ok && rd_ok;
    assign rd_valid = run && rd_more && sink_ok;
    assign wr_valid = out_v && rd_ok;
    assign rd_fire  = rd_valid && rd_ready;
    assign wr_fire  = wr_valid && wr_ready;
endmodule

// File: rtl/pxthr_kernel_chk.sv
// Property checker for pxthr_kernel, observing its ports only.
// Assumes arguments are stable on the accepting edge.
module pxthr_kernel_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [31:0]   n_cols,
    input logic [31:0]   n_rows,
    input logic [31:0]   max_val,
    input logic          busy,
    input logic          done,
    input logic          rd_valid,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ready,
    input logic          wr_valid,
    input logic [AW-1:0] wr_addr,
    input logic [7:0]    wr_data,
    input logic          wr_ready
);
    logic          accept;
    logic [7:0]    max_seen;
    logic [AW-1:0] rd_prev, wr_prev;
    logic          rd_seen, wr_seen;

    assign accept = start && !busy;

    // Track the captured maximum and the last handshake address per port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_seen <= '0;
            rd_prev  <= '0;
            wr_prev  <= '0;
            rd_seen  <= 1'b0;
            wr_seen  <= 1'b0;
        end else if (accept) begin
            max_seen <= max_val[7:0];
            rd_seen  <= 1'b0;
            wr_seen  <= 1'b0;
        end else begin
            if (rd_valid && rd_ready) begin
                rd_prev <= rd_addr;
                rd_seen <= 1'b1;
            end
            if (wr_valid && wr_ready) begin
                wr_prev <= wr_addr;
                wr_seen <= 1'b1;
            end
        end
    end

    p_idle_no_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_valid && !wr_valid));

    p_rd_linear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && rd_seen) |-> (rd_addr == rd_prev + 1'b1));

    p_result_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_data == 8'h00 || wr_data == max_seen));

    p_wr_linear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_seen) |-> (wr_addr == wr_prev + 1'b1));

    p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> ($stable(wr_data) && $stable(wr_addr)));

    p_empty_job_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (n_cols == 0 || n_rows == 0)) |=> (busy && !rd_valid && !wr_valid) ##1 done);

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_ends_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind pxthr_kernel pxthr_kernel_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .n_cols(n_cols), .n_rows(n_rows),
    .max_val(max_val), .busy(busy), .done(done), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
);

// File: tb/pxthr_kernel_test.sv
// Directed bench for pxthr_kernel: a byte-array memory model, a posedge
// monitor logging handshakes, one task per scenario.
module pxthr_kernel_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_base = '0, dst_base = '0, n_cols = '0, n_rows = '0;
    logic [31:0] thresh = '0, max_val = '0;
    logic        busy, done, rd_valid, wr_valid;
    logic [31:0] rd_addr, wr_addr;
    logic [7:0]  rd_data, wr_data;
    logic        rd_ready = 1'b1, wr_ready = 1'b1;

    pxthr_kernel uut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
        .dst_base(dst_base), .n_cols(n_cols), .n_rows(n_rows), .thresh(thresh),
        .max_val(max_val), .busy(busy), .done(done), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    logic [7:0]  src_mem [0:255];
    logic [7:0]  out_mem [0:255];
    logic [31:0] e_src, e_dst;
    int cyc = 0;
    int rd_n, wr_n, rd_first, rd_last, wr_first, wr_last, both_n;
    int done_n, done_edge, acc_edge, addr_err, hold_err;
    logic        held = 1'b0;
    logic [7:0]  hd;
    logic [31:0] ha;
    bit          rmode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // Memory model returns the byte at the read offset in the same cycle.
    always_comb rd_data = src_mem[8'(rd_addr - e_src)];

    // Ready generator, changed on falling edges only.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rmode) begin
            rd_ready = lfsr[0] | lfsr[3];
            wr_ready = lfsr[5] | lfsr[9];
        end else begin
            rd_ready = 1'b1;
            wr_ready = 1'b1;
        end
    end

    // Handshake monitor.
    always @(posedge clk) begin
        if (held && (wr_data !== hd || wr_addr !== ha)) hold_err++;
        held = wr_valid && !wr_ready;
        hd = wr_data;
        ha = wr_addr;
        if (rd_valid && rd_ready) begin
            if (rd_n == 0) rd_first = cyc;
            rd_last = cyc;
            if (rd_addr !== e_src + 32'(rd_n)) addr_err++;
            rd_n++;
        end
        if (wr_valid && wr_ready) begin
            if (wr_n == 0) wr_first = cyc;
            wr_last = cyc;
            if (wr_addr !== e_dst + 32'(wr_n)) addr_err++;
            out_mem[8'(wr_addr - e_dst)] = wr_data;
            wr_n++;
        end
        if (rd_valid && rd_ready && wr_valid && wr_ready) both_n++;
        if (done) begin
            done_n++;
            done_edge = cyc;
        end
        if (start && !busy) acc_edge = cyc;
        cyc++;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        rd_n = 0; wr_n = 0; both_n = 0; done_n = 0; addr_err = 0; hold_err = 0;
        rd_first = 0; rd_last = 0; wr_first = 0; wr_last = 0; done_edge = 0; acc_edge = 0;
        for (int i = 0; i < 256; i++) out_mem[i] = 8'hxx;
    endtask

    // Load pattern, program arguments, start and wait for done.
    task automatic do_run(input int cols, input int rows, input logic [31:0] thr,
                          input logic [31:0] mx, input bit stall, input bit disturb);
        @(negedge clk);
        for (int i = 0; i < 256; i++) src_mem[i] = 8'((i * 37 + 11) & 255);
        src_mem[0] = thr[7:0];
        src_mem[1] = thr[7:0] + 8'd1;
        e_src = 32'h0000_4000; e_dst = 32'h0008_1000;
        src_base = e_src; dst_base = e_dst;
        n_cols = 32'(cols); n_rows = 32'(rows); thresh = thr; max_val = mx;
        rmode = stall;
        clear_log();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (4) @(negedge clk);
            src_base = 32'h0000_9000; dst_base = 32'h0000_0100;
            n_cols = 1; n_rows = 1; thresh = 0; max_val = 32'h7;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_n == 0) @(negedge clk);
        repeat (6) @(negedge clk);
        rmode = 1'b0;
    endtask

    task automatic check_results(input int npix, input logic [31:0] thr,
                                 input logic [31:0] mx, input string req);
        int bad = 0;
        for (int i = 0; i < npix; i++) begin
            logic [7:0] e;
            e = ({24'b0, src_mem[i]} > thr) ? mx[7:0] : 8'h00;
            if (out_mem[i] !== e) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !done && !rd_valid && !wr_valid, "R1 reset outputs",
            {busy, done, rd_valid, wr_valid}, 0);
    endtask

    task automatic t_basic();
        int n = 20;
        do_run(4, 5, 32'd128, 32'd255, 1'b0, 1'b0);
        check_results(n, 32'd128, 32'd255, "R4 threshold results");
        chk(rd_n == n && addr_err == 0, "R3 read count/addresses", rd_n, n);
        chk(wr_n == n, "R5 write count", wr_n, n);
        chk(out_mem[0] == 8'h00 && out_mem[1] == 8'hFF, "R4 equal vs above",
            {out_mem[0], out_mem[1]}, 16'h00FF);
        chk(rd_last - rd_first == n - 1, "R6 one read per cycle", rd_last - rd_first, n - 1);
        chk(wr_first - rd_first == 4, "R7 pixel latency", wr_first - rd_first, 4);
        chk(wr_last - rd_first == n + 3, "R7 run length", wr_last - rd_first, n + 3);
        chk(both_n == n - 4, "R8 concurrent handshakes", both_n, n - 4);
        chk(done_n == 1, "R11 single done", done_n, 1);
        chk(done_edge == wr_last + 2, "R11 done timing", done_edge, wr_last + 2);
        chk(!busy, "R11 busy cleared", busy, 0);
    endtask

    task automatic t_values();
        do_run(3, 3, 32'd100, 32'h1A5, 1'b0, 1'b0);
        check_results(9, 32'd100, 32'h1A5, "R4 low byte of max");
        do_run(2, 2, 32'd300, 32'hFF, 1'b0, 1'b0);
        check_results(4, 32'd300, 32'hFF, "R4 wide threshold");
        do_run(2, 2, 32'd0, 32'hFF, 1'b0, 1'b0);
        chk(out_mem[0] == 8'h00, "R4 zero equals threshold", out_mem[0], 0);
        check_results(4, 32'd0, 32'hFF, "R4 threshold zero");
    endtask

    task automatic t_stall();
        int n = 42;
        do_run(6, 7, 32'd90, 32'hC3, 1'b1, 1'b0);
        check_results(n, 32'd90, 32'hC3, "R9 results under stall");
        chk(wr_n == n && rd_n == n, "R9 no loss or repeat", wr_n, n);
        chk(addr_err == 0, "R5 order under stall", addr_err, 0);
        chk(hold_err == 0, "R9 write held while not ready", hold_err, 0);
    endtask

    task automatic t_busy_start();
        int n = 30;
        do_run(5, 6, 32'd60, 32'h5A, 1'b0, 1'b1);
        check_results(n, 32'd60, 32'h5A, "R12 args latched");
        chk(rd_n == n && addr_err == 0, "R12 length and addresses kept", rd_n, n);
        chk(done_n == 1, "R2 start while busy ignored", done_n, 1);
        chk(!busy, "R2 no second job", busy, 0);
    endtask

    task automatic t_zero();
        @(negedge clk);
        n_cols = 0; n_rows = 9; e_src = 0; e_dst = 0;
        clear_log();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R10 busy after accept", {busy, done}, 2);
        @(negedge clk);
        chk(done && !busy, "R10 done next cycle", {busy, done}, 1);
        repeat (3) @(negedge clk);
        chk(rd_n == 0 && wr_n == 0, "R10 no memory access", rd_n + wr_n, 0);
        chk(done_edge - acc_edge == 2, "R10 done edge", done_edge - acc_edge, 2);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected 0", 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_values();
        t_stall();
        t_busy_start();
        t_zero();
        summary();
        $finish;
    end
endmodule